// File: doc/BRIEF.md
# Serial Control Word Receiver

This block is the three-wire serial control port of an audio converter. An external controller drives a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock moves one data bit into an 8-bit shift register. A rising edge of the load strobe then commits the assembled word into one of two control register sets.

The top bit of the word selects the destination. With the top bit clear, the remaining seven bits become the attenuation code. With the top bit set, two of the remaining bits become the de-emphasis enable and the de-emphasis mode, and the other bits are unused. The three inputs are asynchronous to the block's fast system clock. Each one is synchronized and edge-detected before use, so the system clock must run at least four times faster than the serial clock.

The block also checks the protocol. If the strobe rises too soon after the last serial clock edge, a sticky gap-error flag is set, but the word is still committed. If the strobe rises before a complete word has been shifted in, the word is thrown away and a sticky short-word flag is set. Two further flags report whether each register set has been written since reset.

Top module: `scw_ctrl_port`

## Requirements
- R1: Each of the three inputs passes through a two-flop synchronizer, and only rising edges act. A strobe rising edge first sampled at system clock edge e changes the outputs at edge e+2. That change is visible after edge e+2 and not after edges e or e+1.
- R2: Bits are sent least-significant first. The first bit received after a commit ends up as D0, and the eighth ends up as D7, the top bit.
- R3: A committed word with D7 = 0 sets the attenuation code (gain_code_o) to D6..D0 and leaves both de-emphasis outputs unchanged.
- R4: A committed word with D7 = 1 sets emph_sel_o to D6 and emph_on_o to D5. D4..D0 are ignored, and the attenuation code is unchanged.
- R5: Each register set keeps its value until the next committed word aimed at that same set.
- R6: The gap is the number of system clock cycles between the synchronized last serial-clock rising edge and the synchronized strobe rising edge. A gap smaller than MIN_GAP (default 150, which is 1.5 µs at 100 MHz) sets gap_err_o. The flag stays set until reset, and the word is still committed. A gap of exactly MIN_GAP is accepted.
- R7: A strobe rising edge that comes after fewer than 8 serial-clock rising edges since the previous strobe edge (or since reset) discards the word and sets short_err_o, which stays set until reset. If more than 8 bits arrive, the last 8 received form the word.
- R8: Reset is synchronous and active high. It sets gain_code_o to 0, emph_on_o and emph_sel_o to 0, and clears all four flags.
- R9: gain_written_o goes to 1 on the first committed word with D7 = 0, and emph_written_o goes to 1 on the first committed word with D7 = 1. Each stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Asynchronous load strobe; a rising edge commits the word |
| sclk_i | input | 1 | Asynchronous serial clock |
| sdata_i | input | 1 | Asynchronous serial data, sampled on a serial clock rising edge |
| gain_code_o | output | 7 | Attenuation code |
| emph_on_o | output | 1 | De-emphasis enable |
| emph_sel_o | output | 1 | De-emphasis mode select |
| gain_written_o | output | 1 | Attenuation set written since reset |
| emph_written_o | output | 1 | De-emphasis set written since reset |
| gap_err_o | output | 1 | Sticky strobe-too-early flag |
| short_err_o | output | 1 | Sticky incomplete-word flag |

## Verification
Some properties are checked by assertions on every cycle:
- a synchronized edge pulse lasts one cycle;
- both register sets hold their value when no strobe edge arrives;
- a short word changes neither set;
- a word sent to one set leaves the other set alone;
- the error and written flags, once set, stay set;
- the gap and bit counters stay within their limits.

Other behaviours need the bench's scenarios, which are compared against a behavioural reference model:
- the least-significant-first bit order;
- the exact field mapping of each word type;
- the two-cycle commit latency;
- the exact gap boundary at MIN_GAP against MIN_GAP - 1;
- keeping the last eight bits of an over-long word.

// File: rtl/scw_pkg.sv
package scw_pkg;

    localparam int WORD_W = 8;
    localparam int GAIN_W = WORD_W - 1;
    localparam int SEL_BIT = WORD_W - 1;
    localparam int EMPH_SEL_BIT = WORD_W - 2;
    localparam int EMPH_ON_BIT = WORD_W - 3;
    localparam int NUM_INPUTS = 3;

    localparam int IDX_DATA = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_STB = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [GAIN_W-1:0] gain_t;

    typedef enum logic {
        DEST_GAIN = 1'b0,
        DEST_EMPH = 1'b1
    } dest_e;

    typedef struct packed {
        logic sel;
        logic on;
    } emph_t;

    function automatic dest_e word_dest(input word_t w);
        return dest_e'(w[SEL_BIT]);
    endfunction

    function automatic gain_t word_gain(input word_t w);
        return w[GAIN_W-1:0];
    endfunction

    function automatic emph_t word_emph(input word_t w);
        emph_t e;
        e.sel = w[EMPH_SEL_BIT];
        e.on = w[EMPH_ON_BIT];
        return e;
    endfunction

endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);

    for (genvar gi = 0; gi < N; gi++) begin : g_ch
        logic meta_q;
        logic stab_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= async_i[gi];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        assign level_o[gi] = stab_q;
        assign rise_o[gi] = stab_q & ~prev_q;

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            rise_o[gi] |=> !rise_o[gi]); // R1
    end

endmodule

// File: rtl/scw_shifter.sv
module scw_shifter
    import scw_pkg::*;
#(
    parameter int MIN_GAP = 150
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_rise,
    input  logic  sdata_lvl,
    input  logic  stb_rise,
    output word_t word_o,
    output logic  full_o,
    output logic  gap_short_o
);

    localparam int GAP_W = $clog2(MIN_GAP + 1);
    localparam int CNT_W = $clog2(WORD_W + 1);

    word_t            shreg_q;
    logic [CNT_W-1:0] bits_q;
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (sclk_rise) begin
            shreg_q <= {sdata_lvl, shreg_q[WORD_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (stb_rise) begin
            bits_q <= '0;
        end else if (sclk_rise && (bits_q < CNT_W'(WORD_W))) begin
            bits_q <= bits_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_W'(MIN_GAP);
        end else if (sclk_rise) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q < GAP_W'(MIN_GAP)) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assign word_o = shreg_q;
    assign full_o = (bits_q == CNT_W'(WORD_W));
    assign gap_short_o = (gap_q < GAP_W'(MIN_GAP));

    AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        bits_q <= CNT_W'(WORD_W)); // R7
    AST_GAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        gap_q <= GAP_W'(MIN_GAP)); // R6

endmodule

// File: rtl/scw_regs.sv
module scw_regs
    import scw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  stb_rise,
    input  word_t word_i,
    input  logic  full_i,
    input  logic  gap_short_i,
    output gain_t gain_o,
    output emph_t emph_o,
    output logic  gain_wr_o,
    output logic  emph_wr_o,
    output logic  gap_err_o,
    output logic  short_err_o
);

    logic  commit;
    logic  ld_gain;
    logic  ld_emph;
    gain_t gain_q;
    emph_t emph_q;

    assign commit = stb_rise & full_i;
    assign ld_gain = commit & (word_dest(word_i) == DEST_GAIN);
    assign ld_emph = commit & (word_dest(word_i) == DEST_EMPH);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q <= '0;
            gain_wr_o <= 1'b0;
        end else if (ld_gain) begin
            gain_q <= word_gain(word_i);
            gain_wr_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            emph_q <= '0;
            emph_wr_o <= 1'b0;
        end else if (ld_emph) begin
            emph_q <= word_emph(word_i);
            emph_wr_o <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_err_o <= 1'b0;
            short_err_o <= 1'b0;
        end else if (stb_rise) begin
            if (gap_short_i) gap_err_o <= 1'b1;
            if (!full_i) short_err_o <= 1'b1;
        end
    end

    assign gain_o = gain_q;
    assign emph_o = emph_q;

    AST_LOADS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_gain, ld_emph})); // R3

endmodule

// File: rtl/scw_ctrl_port.sv
module scw_ctrl_port
    import scw_pkg::*;
#(
    parameter int MIN_GAP = 150
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_i,
    input  logic              sclk_i,
    input  logic              sdata_i,
    output logic [GAIN_W-1:0] gain_code_o,
    output logic              emph_on_o,
    output logic              emph_sel_o,
    output logic              gain_written_o,
    output logic              emph_written_o,
    output logic              gap_err_o,
    output logic              short_err_o
);

    logic [NUM_INPUTS-1:0] async_in;
    logic [NUM_INPUTS-1:0] lvl;
    logic [NUM_INPUTS-1:0] rise;
    word_t                 word;
    logic                  full;
    logic                  gap_short;
    gain_t                 gain;
    emph_t                 emph;

    assign async_in[IDX_DATA] = sdata_i;
    assign async_in[IDX_SCLK] = sclk_i;
    assign async_in[IDX_STB] = strobe_i;

    scw_sync #(.N(NUM_INPUTS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (async_in),
        .level_o (lvl),
        .rise_o  (rise)
    );

    scw_shifter #(.MIN_GAP(MIN_GAP)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .sclk_rise   (rise[IDX_SCLK]),
        .sdata_lvl   (lvl[IDX_DATA]),
        .stb_rise    (rise[IDX_STB]),
        .word_o      (word),
        .full_o      (full),
        .gap_short_o (gap_short)
    );

    scw_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .stb_rise    (rise[IDX_STB]),
        .word_i      (word),
        .full_i      (full),
        .gap_short_i (gap_short),
        .gain_o      (gain),
        .emph_o      (emph),
        .gain_wr_o   (gain_written_o),
        .emph_wr_o   (emph_written_o),
        .gap_err_o   (gap_err_o),
        .short_err_o (short_err_o)
    );

    assign gain_code_o = gain;
    assign emph_on_o = emph.on;
    assign emph_sel_o = emph.sel;

    AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rise[IDX_STB] |=> $stable(gain_code_o)); // R5
    AST_EMPH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rise[IDX_STB] |=> $stable({emph_on_o, emph_sel_o})); // R5
    AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (rise[IDX_STB] && !full) |=> ($stable(gain_code_o) && $stable({emph_on_o, emph_sel_o}))); // R7
    AST_GAIN_WORD_KEEPS_EMPH: assert property (@(posedge clk) disable iff (rst)
        (rise[IDX_STB] && !word[SEL_BIT]) |=> $stable({emph_on_o, emph_sel_o})); // R3
    AST_EMPH_WORD_KEEPS_GAIN: assert property (@(posedge clk) disable iff (rst)
        (rise[IDX_STB] && word[SEL_BIT]) |=> $stable(gain_code_o)); // R4
    AST_GAP_STICKY: assert property (@(posedge clk) disable iff (rst)
        gap_err_o |=> gap_err_o); // R6
    AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        short_err_o |=> short_err_o); // R7
    AST_WRITTEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (gain_written_o || emph_written_o) |=>
        ($past(gain_written_o) <= gain_written_o && $past(emph_written_o) <= emph_written_o)); // R9

endmodule

// File: tb/scw_ctrl_port_bench.sv
module scw_ctrl_port_bench;

    localparam int MIN_GAP = 150;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [6:0] gain_code;
    logic       emph_on, emph_sel, gain_wr, emph_wr, gap_err, short_err;

    int compared = 0;
    int mismatched = 0;
    bit started = 0;
    bit done = 0;

    always #5 clk = ~clk;

    scw_ctrl_port #(.MIN_GAP(MIN_GAP)) u_scw_ctrl_port (
        .clk            (clk),
        .rst            (rst),
        .strobe_i       (strobe),
        .sclk_i         (sclk),
        .sdata_i        (sdata),
        .gain_code_o    (gain_code),
        .emph_on_o      (emph_on),
        .emph_sel_o     (emph_sel),
        .gain_written_o (gain_wr),
        .emph_written_o (emph_wr),
        .gap_err_o      (gap_err),
        .short_err_o    (short_err)
    );

    // Behavioural reference model: input history, bit list, elapsed-cycle counter
    logic [2:0] hist[$] = '{3'b0, 3'b0, 3'b0, 3'b0};
    bit         rx_bits[$];
    int         m_gap = MIN_GAP;
    int         m_gain = 0;
    int         m_on = 0, m_sel = 0, m_gwr = 0, m_ewr = 0, m_gerr = 0, m_serr = 0;

    always @(posedge clk) begin
        logic [2:0] now, old;
        int w;
        hist.push_front(rst ? 3'b0 : {strobe, sclk, sdata});
        void'(hist.pop_back());
        if (rst) begin
            rx_bits.delete();
            m_gap = MIN_GAP; m_gain = 0; m_on = 0; m_sel = 0;
            m_gwr = 0; m_ewr = 0; m_gerr = 0; m_serr = 0;
        end else begin
            now = hist[2];
            old = hist[3];
            if (now[2] && !old[2]) begin
                if (m_gap < MIN_GAP) m_gerr = 1;
                if (rx_bits.size() < 8) begin
                    m_serr = 1;
                end else begin
                    w = 0;
                    for (int k = 0; k < 8; k++)
                        if (rx_bits[rx_bits.size() - 8 + k]) w += (1 << k);
                    if (w >= 128) begin
                        m_sel = (w >> 6) & 1; m_on = (w >> 5) & 1; m_ewr = 1;
                    end else begin
                        m_gain = w; m_gwr = 1;
                    end
                end
                rx_bits.delete();
            end
            if (m_gap < MIN_GAP) m_gap++;
            if (now[1] && !old[1]) begin
                rx_bits.push_back(now[0]);
                m_gap = 1;
            end
        end
        started = 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            check("R3", "model gain_code", int'(gain_code), m_gain);
            check("R4", "model emph_on", int'(emph_on), m_on);
            check("R4", "model emph_sel", int'(emph_sel), m_sel);
            check("R9", "model gain_written", int'(gain_wr), m_gwr);
            check("R9", "model emph_written", int'(emph_wr), m_ewr);
            check("R6", "model gap_err", int'(gap_err), m_gerr);
            check("R7", "model short_err", int'(short_err), m_serr);
        end
    end

    // Send n bits LSB first, then wait 'gap' more negedges and pulse the strobe.
    // Cycles from the last serial rising edge to the strobe edge = 6 + gap.
    // If tmg_old >= 0, check the R1 commit latency on gain_code.
    task automatic send(input logic [15:0] bits, input int n, input int gap,
                        input int tmg_old = -1, input int tmg_new = 0);
        for (int i = 0; i < n; i++) begin
            sdata = bits[i];
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (gap) @(negedge clk);
        strobe = 1'b1;
        if (tmg_old >= 0) begin
            @(negedge clk); check("R1", "gain after edge e", int'(gain_code), tmg_old);
            @(negedge clk); check("R1", "gain after edge e+1", int'(gain_code), tmg_old);
            @(negedge clk); check("R1", "gain after edge e+2", int'(gain_code), tmg_new);
            @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
        strobe = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R8", "reset gain", int'(gain_code), 0);
        check("R8", "reset emph_on", int'(emph_on), 0);
        check("R8", "reset flags", int'({gain_wr, emph_wr, gap_err, short_err}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R2 / R3: asymmetric code checks bit order; R1 latency
        send(16'h002B, 8, 160, 0, 'h2B);
        check("R2", "gain LSB-first 0x2B", int'(gain_code), 'h2B);
        check("R9", "gain written", int'(gain_wr), 1);
        check("R9", "emph not yet written", int'(emph_wr), 0);

        // R4: D7=1, D6=1, D5=0, D4..D0 all ones (ignored)
        send(16'h00DF, 8, 160);
        check("R4", "emph_sel", int'(emph_sel), 1);
        check("R4", "emph_on", int'(emph_on), 0);
        check("R4", "gain kept", int'(gain_code), 'h2B);
        check("R9", "emph written", int'(emph_wr), 1);

        // R4: D6=0, D5=1
        send(16'h00A0, 8, 160);
        check("R4", "emph_on set", int'(emph_on), 1);
        check("R4", "emph_sel clear", int'(emph_sel), 0);

        // R3 / R5: full-scale code, emphasis retained
        send(16'h007F, 8, 160);
        check("R3", "gain 0x7F", int'(gain_code), 'h7F);
        check("R5", "emph_on retained", int'(emph_on), 1);
        send(16'h0000, 8, 160);
        check("R3", "gain 0x00", int'(gain_code), 0);

        // R6 boundary: gap exactly MIN_GAP accepted
        send(16'h0055, 8, MIN_GAP - 6);
        check("R6", "gap==MIN no error", int'(gap_err), 0);
        check("R3", "gain 0x55", int'(gain_code), 'h55);

        // R6: gap MIN_GAP-1 flags, word still applied
        send(16'h0033, 8, MIN_GAP - 7);
        check("R6", "gap==MIN-1 error", int'(gap_err), 1);
        check("R6", "word applied", int'(gain_code), 'h33);

        // R7: 5-bit word discarded
        send(16'h0011, 5, 160);
        check("R7", "short flag", int'(short_err), 1);
        check("R7", "gain unchanged", int'(gain_code), 'h33);

        // R7 / R2: 10 bits, last 8 used (0x11 after two junk ones)
        send(16'h0047, 10, 160);
        check("R7", "long word last 8 bits", int'(gain_code), 'h11);
        check("R6", "gap flag sticky", int'(gap_err), 1);

        // R8: reset mid-run
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8", "re-reset gain", int'(gain_code), 0);
        check("R8", "re-reset emph", int'({emph_on, emph_sel}), 0);
        check("R8", "re-reset flags", int'({gain_wr, emph_wr, gap_err, short_err}), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        send(16'h0009, 8, 160);
        check("R3", "after reset gain", int'(gain_code), 9);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule